// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects three interrupt causes from a graphics engine and raises one interrupt line toward the host. Two of the causes are single-cycle events: the renderer finishing a frame and the binner completing its final flush. The third is a condition rather than an event. The binner is starved of overflow memory whenever the overflow size register holds zero. Software sees a status word that it clears by writing ones. It also sees an enable mask with two write ports, one that only sets bits and one that only clears them.

The out-of-memory condition is level-like. Its status bit is set again on every clock for as long as no overflow memory is present, so a clear only takes effect once software has supplied memory. Software supplies memory by writing a base address and then a nonzero size. When the binner adopts that memory it pulses a take strobe. This zeroes the held size, so the condition returns until software supplies more memory.

Top module: `gic_top`

## Requirements
- R1: During reset and right after it, the enable mask, the overflow base and the overflow size are all zero, and `irq` is low.
- R2: A write to word 0 (status) clears each status bit whose data bit is 1. Bits written as 0 keep their value.
- R3: A write to word 1 (enable set) sets each enable bit whose data bit is 1. Other enable bits are unchanged.
- R4: A write to word 2 (enable clear) clears each enable bit whose data bit is 1. Other enable bits are unchanged.
- R5: A read of word 1 and a read of word 2 both return the current enable mask.
- R6: A `frame_done` or `flush_done` pulse sets its status bit on the next edge. Once cleared, that bit stays clear until the next pulse.
- R7: While the overflow size is zero, status bit 2 is set on every edge, including the edge right after a clear of that bit.
- R8: Words 3 and 4 hold the overflow base and size and drive `ovf_base` and `ovf_size`. A nonzero size removes the out-of-memory cause, so a later clear of bit 2 holds.
- R9: An `ovf_take` pulse zeroes the overflow size on the next edge. A write of word 4 on the same edge wins over the pulse.
- R10: `irq` is high exactly when some bit is set in both the status word and the enable mask. Disabled sources still set their status bits.
- R11: Bit 0 is frame done, bit 1 is flush done and bit 2 is out of memory. Higher status and enable bits read as zero and ignore writes. Words 5 to 7 read as zero.
- R12: When a source event and a clear of the same status bit fall on one edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W (3) | Word index |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| frame_done | input | 1 | Renderer frame-complete pulse |
| flush_done | input | 1 | Binner final-flush pulse |
| ovf_take | input | 1 | Binner has adopted the overflow memory |
| ovf_base | output | DATA_W (32) | Overflow memory base address |
| ovf_size | output | DATA_W (32) | Overflow memory size, zero means none |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall on the same edge. The first pair is a source setting a status bit while software clears that bit. The second is the binner taking the overflow memory while software writes a new size. The bench provokes both by asserting the event inputs in the same cycle as a write to the status word or the size word. It sweeps every combination of the two pulse events with every 3-bit clear pattern, under both zero and nonzero overflow size. After each edge it predicts status, mask, overflow registers and `irq` from a bench model of the requirements and compares them with the registers read back over the bus.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int NSRC = 3;
  localparam int BIT_FRAME = 0;
  localparam int BIT_FLUSH = 1;
  localparam int BIT_OOM   = 2;

  typedef enum logic [2:0] {
    W_STATUS = 3'd0,
    W_ENSET  = 3'd1,
    W_ENCLR  = 3'd2,
    W_BASE   = 3'd3,
    W_SIZE   = 3'd4
  } word_e;

  // status update: clear-by-one first, then a same-edge event re-sets
  function automatic logic [NSRC-1:0] w1c_next(input logic [NSRC-1:0] cur,
                                               input logic [NSRC-1:0] clr,
                                               input logic [NSRC-1:0] ev);
    return (cur & ~clr) | ev;
  endfunction

  function automatic logic [NSRC-1:0] mask_next(input logic [NSRC-1:0] cur,
                                                input logic [NSRC-1:0] set,
                                                input logic [NSRC-1:0] clr);
    return (cur | set) & ~clr;
  endfunction
endpackage

// File: rtl/gic_status.sv
module gic_status
  import gic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts <= '0;
    else        sts <= w1c_next(sts, clr, ev);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R12 / R6 / R7: an event always lands, even against a clear
    assert_event_sets_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> sts[i]);
    // R2: a clear without a competing event empties the bit
    assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !ev[i]) |=> !sts[i]);
    // R2: no clear and no event leaves the bit alone
    assert_w1c_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[i] && !ev[i]) |=> (sts[i] == $past(sts[i])));
  end
endmodule

// File: rtl/gic_enable.sv
module gic_enable
  import gic_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= mask_next(en, set, clr);
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && !clr[i]) |=> en[i]);
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] |=> !en[i]);
  end
endmodule

// File: rtl/gic_ovf.sv
module gic_ovf #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_size,
  input  logic              take,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] base,
  output logic [DATA_W-1:0] size,
  output logic              starved
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      size <= '0;
    end else begin
      if (wr_base) base <= wdata;
      if (wr_size)   size <= wdata;
      else if (take) size <= '0;
    end
  end

  assign starved = (size == '0);

  assert_take_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_size) |=> (size == '0));
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_size |=> (size == $past(wdata)));
  assert_base_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_base |=> $stable(base));
endmodule

// File: rtl/gic_top.sv
module gic_top
  import gic_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frame_done,
  input  logic              flush_done,
  input  logic              ovf_take,
  output logic [DATA_W-1:0] ovf_base,
  output logic [DATA_W-1:0] ovf_size,
  output logic              irq
);
  localparam int PAD_W = DATA_W - NSRC;

  logic            hit_sts, hit_set, hit_clr, hit_base, hit_size;
  logic [NSRC-1:0] wbits, sts_clr, en_set, en_clr, events;
  logic [NSRC-1:0] sts, en, pending;
  logic            starved;

  assign hit_sts  = bus_wr && (bus_addr == ADDR_W'(W_STATUS));
  assign hit_set  = bus_wr && (bus_addr == ADDR_W'(W_ENSET));
  assign hit_clr  = bus_wr && (bus_addr == ADDR_W'(W_ENCLR));
  assign hit_base = bus_wr && (bus_addr == ADDR_W'(W_BASE));
  assign hit_size = bus_wr && (bus_addr == ADDR_W'(W_SIZE));

  assign wbits   = bus_wdata[NSRC-1:0];
  assign sts_clr = hit_sts ? wbits : '0;
  assign en_set  = hit_set ? wbits : '0;
  assign en_clr  = hit_clr ? wbits : '0;

  always_comb begin
    events            = '0;
    events[BIT_FRAME] = frame_done;
    events[BIT_FLUSH] = flush_done;
    events[BIT_OOM]   = starved;
  end

  gic_status u_sts (.clk(clk), .rst_n(rst_n), .ev(events), .clr(sts_clr), .sts(sts));
  gic_enable u_en  (.clk(clk), .rst_n(rst_n), .set(en_set), .clr(en_clr), .en(en));
  gic_ovf #(.DATA_W(DATA_W)) u_ovf (
    .clk(clk), .rst_n(rst_n), .wr_base(hit_base), .wr_size(hit_size),
    .take(ovf_take), .wdata(bus_wdata), .base(ovf_base), .size(ovf_size),
    .starved(starved));

  assign pending = sts & en;
  assign irq     = |pending;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(W_STATUS): bus_rdata = {{PAD_W{1'b0}}, sts};
      ADDR_W'(W_ENSET),
      ADDR_W'(W_ENCLR):  bus_rdata = {{PAD_W{1'b0}}, en};
      ADDR_W'(W_BASE):   bus_rdata = ovf_base;
      ADDR_W'(W_SIZE):   bus_rdata = ovf_size;
      default:           bus_rdata = '0;
    endcase
  end

  // R7: with no overflow memory the out-of-memory bit is set after every edge
  assert_oom_relatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_size == '0) |=> sts[BIT_OOM]);
  // R10: the line needs an enabled source and a pending status bit
  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en != '0) && (sts != '0)));
  // R1: reset leaves the line low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> !irq);
endmodule

// File: tb/sim_gic_top.sv
module sim_gic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        frame_done = 1'b0, flush_done = 1'b0, ovf_take = 1'b0;
  logic [31:0] ovf_base, ovf_size;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the registers
  logic [2:0]  m_sts = '0, m_en = '0;
  logic [31:0] m_base = '0, m_size = '0;

  always #10 clk = ~clk;

  gic_top u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done),
    .flush_done(flush_done), .ovf_take(ovf_take), .ovf_base(ovf_base),
    .ovf_size(ovf_size), .irq(irq));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic check_all(input string req);
    logic [31:0] d;
    rd(3'd0, d); check(req, "status", d, {29'd0, m_sts});
    rd(3'd1, d); check(req, "enset read", d, {29'd0, m_en});
    rd(3'd2, d); check("R5", "enclr read", d, {29'd0, m_en});
    rd(3'd3, d); check(req, "base", d, m_base);
    rd(3'd4, d); check(req, "size", d, m_size);
    check(req, "size port", ovf_size, m_size);
    check(req, "base port", ovf_base, m_base);
    check("R10", "irq", {31'd0, irq}, {31'd0, |(m_sts & m_en)});
  endtask

  // one clock: optional write plus source inputs, model advanced per requirements
  task automatic step(input string req, input logic wr, input logic [2:0] a,
                      input logic [31:0] d, input logic fr, input logic fl,
                      input logic tk);
    logic [2:0] ev, clr, set, dis;
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    frame_done = fr; flush_done = fl; ovf_take = tk;
    ev  = {m_size == 32'd0, fl, fr};          // R11 bit map
    clr = (wr && a == 3'd0) ? d[2:0] : 3'd0;
    set = (wr && a == 3'd1) ? d[2:0] : 3'd0;
    dis = (wr && a == 3'd2) ? d[2:0] : 3'd0;
    m_sts = (m_sts & ~clr) | ev;              // R2, R12
    m_en  = (m_en | set) & ~dis;              // R3, R4
    if (wr && a == 3'd3) m_base = d;
    if (wr && a == 3'd4) m_size = d;          // R9 write wins
    else if (tk)         m_size = 32'd0;
    @(negedge clk);
    bus_wr = 1'b0; frame_done = 1'b0; flush_done = 1'b0; ovf_take = 1'b0;
    check_all(req);
  endtask

  initial begin
    logic [31:0] d;
    #25;
    check("R1", "irq in reset", {31'd0, irq}, 32'd0);
    rd(3'd1, d); check("R1", "enable in reset", d, 32'd0);
    rd(3'd4, d); check("R1", "size in reset", d, 32'd0);
    rd(3'd3, d); check("R1", "base in reset", d, 32'd0);
    rst_n = 1'b1;
    step("R7", 1'b0, 3'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);

    // R3 / R4 sweep of the mask ports, upper bits set to probe R11
    for (int s = 0; s < 8; s++) step("R3", 1'b1, 3'd1, 32'hFFFF_FFF8 | s, 1'b0, 1'b0, 1'b0);
    for (int c = 0; c < 8; c++) step("R4", 1'b1, 3'd2, 32'hFFFF_FFF8 | c, 1'b0, 1'b0, 1'b0);
    for (int s = 0; s < 8; s++) begin
      step("R3", 1'b1, 3'd1, s, 1'b0, 1'b0, 1'b0);
      step("R4", 1'b1, 3'd2, 7 - s, 1'b0, 1'b0, 1'b0);
    end

    // R7: out-of-memory bit comes back after each clear while size is zero
    step("R7", 1'b1, 3'd0, 32'd4, 1'b0, 1'b0, 1'b0);
    rd(3'd0, d); check("R7", "oom re-latched", d & 32'd4, 32'd4);

    // event / clear sweep, starved then supplied (R6, R12, R2)
    for (int p = 0; p < 2; p++) begin
      for (int e = 0; e < 4; e++)
        for (int c = 0; c < 8; c++) begin
          step("R12", 1'b1, 3'd0, 32'hFFFF_FFF8 | c, e[0], e[1], 1'b0);
          step("R6", 1'b1, 3'd0, 32'd3, 1'b0, 1'b0, 1'b0);
        end
      if (p == 0) begin
        step("R8", 1'b1, 3'd3, 32'h8000_1000, 1'b0, 1'b0, 1'b0);
        step("R8", 1'b1, 3'd4, 32'h0000_4000, 1'b0, 1'b0, 1'b0);
        step("R8", 1'b1, 3'd0, 32'd7, 1'b0, 1'b0, 1'b0);
        rd(3'd0, d); check("R8", "oom stays cleared", d, 32'd0);
      end
    end

    // R10: each source alone with each mask
    for (int m = 0; m < 8; m++) begin
      step("R10", 1'b1, 3'd2, 32'd7, 1'b0, 1'b0, 1'b0);
      step("R10", 1'b1, 3'd1, m, 1'b0, 1'b0, 1'b0);
      step("R10", 1'b0, 3'd0, 32'd0, m[0], m[1] ^ m[0], 1'b0);
      step("R10", 1'b1, 3'd0, 32'd7, 1'b0, 1'b0, 1'b0);
    end

    // R9: take empties size, then collision of take with a size write
    step("R9", 1'b0, 3'd0, 32'd0, 1'b0, 1'b0, 1'b1);
    rd(3'd4, d); check("R9", "size after take", d, 32'd0);
    step("R9", 1'b1, 3'd0, 32'd4, 1'b0, 1'b0, 1'b0);
    step("R9", 1'b1, 3'd4, 32'h0000_0800, 1'b0, 1'b0, 1'b1);
    rd(3'd4, d); check("R9", "write beats take", d, 32'h0000_0800);
    step("R9", 1'b1, 3'd0, 32'd4, 1'b0, 1'b0, 1'b0);
    step("R8", 1'b0, 3'd0, 32'd0, 1'b0, 1'b0, 1'b0);

    // R11: unmapped words read zero and writes there change nothing
    for (int a = 5; a < 8; a++) begin
      step("R11", 1'b1, a[2:0], 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0);
      rd(a[2:0], d); check("R11", "unmapped read", d, 32'd0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule